// File: doc/BRIEF.md
# Sync Word Normalizer for a Parallel Video Serializer Input

This block is the first stage in front of a serial digital video serializer. On every rising edge of the parallel clock it captures a 10-bit input word, then looks at the reserved values that timing reference sequences use. When the eight high bits are all zeros or all ones, it overwrites the two low bits to match them. A source that carries only eight significant bits therefore still produces the legal 10-bit values 000 and 3FF. When the disable input is high, words pass through untouched, so the same port can carry parallel data that is not video.

The normalized word leaves through an output register, two parallel clocks after it enters. A small state machine follows the normalized stream and raises a one-cycle marker on the last word of each 3FF, 000, 000 preamble. The marker is aligned with that word on the output. The state machine has three states:
- `PRE_IDLE`: nothing matched yet.
- `PRE_ONES`: a 3FF was just seen.
- `PRE_ZERO1`: 3FF followed by one 000.

Its transitions are:
- *see_ones*: any state goes to `PRE_ONES` on 3FF.
- *first_zero*: `PRE_ONES` goes to `PRE_ZERO1` on 000.
- *complete*: `PRE_ZERO1` returns to `PRE_IDLE` on 000 and fires the marker.
- *break*: any other word returns to `PRE_IDLE`.
- *bypass*: a disabled word forces `PRE_IDLE`.
- *clear*: reset forces `PRE_IDLE`.

Top module: `trs_word_normalizer`

## Requirements
- R1: With the disable input low, an input whose bits 9..2 are all zero (bit 0 is the LSB, bit 9 the MSB), i.e. 000 to 003, appears on the output as 000.
- R2: With the disable input low, an input whose bits 9..2 are all one, i.e. 3FC to 3FF, appears on the output as 3FF.
- R3: With the disable input low, any other input value appears on the output unchanged.
- R4: With the disable input high, every input value, including 000-003 and 3FC-3FF, appears on the output unchanged.
- R5: The output word presented with an input at one rising edge appears after the second rising edge that follows, with the disable input sampled together with that word.
- R6: The preamble marker is high for exactly the output cycle that carries the third word of a normalized 3FF, 000, 000 sequence. This includes sequences that become 3FF, 000, 000 only through R1 and R2, such as 3FE, 002, 001.
- R7: The marker is never high on two consecutive cycles; a fourth consecutive 000 does not raise it.
- R8: The marker stays low for any word taken in with the disable input high, and such a word breaks a preamble in progress.
- R9: A synchronous active-high reset sets the output word to 000 and the marker low. It also drops any partial preamble, so a sequence interrupted by reset never completes.
- R10: Repeated 3FF words before the zeros still form a preamble; any word other than 000 or 3FF after a 3FF restarts the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sync_dis | input | 1 | High: pass words through with no mapping and no preamble search |
| word_in | input | 10 | Parallel input word, bit 0 is the LSB |
| word_out | output | 10 | Normalized word, two clocks after input |
| preamble_flag | output | 1 | One-cycle marker on the last word of a 3FF, 000, 000 preamble |

## Verification
The mapping is tried with all four values of each reserved range, against neighbours just outside them (004, 3FB), and with ordinary mid-range words. This separates forcing of the low bits from plain pass-through. The same reserved values are repeated with the disable input high, which shows that bypass suppresses both the mapping and the marker.

Preamble tracking is tried with several sequences, each with its own purpose:
- A clean 3FF, 000, 000 preamble.
- An eight-bit style 3FC, 003, 001 preamble.
- A run of four zeros, which must fire only once.
- Doubled 3FF words.
- A preamble broken by a stray value.
- A preamble broken by a bypassed word.
- A preamble cut by reset.

Together these separate a correct tracker from one that counts raw input words, one that re-fires, or one that forgets to restart.

// File: rtl/trs_norm_pkg.sv
package trs_norm_pkg;

    // Preamble search progress through the normalized stream
    typedef enum logic [1:0] {
        PRE_IDLE  = 2'd0,
        PRE_ONES  = 2'd1,
        PRE_ZERO1 = 2'd2
    } pre_state_e;

    // Width of the field whose value is rewritten for reserved words
    localparam int unsigned FORCED_LOW_BITS = 2;

endpackage

// File: rtl/trs_input_latch.sv
module trs_input_latch #(
    parameter int unsigned WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] d_word,
    input  logic              d_dis,
    output logic [WORD_W-1:0] q_word,
    output logic              q_dis
);

    // Capture the parallel word and its bypass control together
    always_ff @(posedge clk) begin
        if (rst) begin
            q_word <= '0;
            q_dis  <= 1'b0;
        end else begin
            q_word <= d_word;
            q_dis  <= d_dis;
        end
    end

endmodule

// File: rtl/trs_word_mapper.sv
module trs_word_mapper #(
    parameter int unsigned WORD_W = 10,
    parameter int unsigned LOW_W  = 2
) (
    input  logic [WORD_W-1:0] raw_word,
    input  logic              bypass,
    output logic [WORD_W-1:0] norm_word,
    output logic              is_all_ones,
    output logic              is_all_zero
);

    localparam int unsigned HIGH_W = WORD_W - LOW_W;

    logic [HIGH_W-1:0] high_part;
    logic              high_zero;
    logic              high_ones;
    logic [LOW_W-1:0]  low_forced;

    assign high_part = raw_word[WORD_W-1:LOW_W];
    assign high_zero = ~|high_part;
    assign high_ones = &high_part;

    // Each low bit copies the high-part state when a reserved word is seen
    for (genvar b = 0; b < LOW_W; b++) begin : g_low
        always_comb begin
            if (bypass) begin
                low_forced[b] = raw_word[b];
            end else if (high_zero) begin
                low_forced[b] = 1'b0;
            end else if (high_ones) begin
                low_forced[b] = 1'b1;
            end else begin
                low_forced[b] = raw_word[b];
            end
        end
    end

    assign norm_word   = {high_part, low_forced};
    assign is_all_ones = !bypass && (&norm_word);
    assign is_all_zero = !bypass && (norm_word == '0);

endmodule

// File: rtl/trs_preamble_fsm.sv
module trs_preamble_fsm
    import trs_norm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bypass,
    input  logic word_ones,
    input  logic word_zero,
    output logic found
);

    pre_state_e state_q;
    pre_state_e state_d;
    logic       found_d;

    // Next state and marker decision
    always_comb begin
        state_d = PRE_IDLE;
        found_d = 1'b0;
        if (bypass) begin
            state_d = PRE_IDLE;
        end else begin
            unique case (state_q)
                PRE_IDLE: begin
                    if (word_ones) state_d = PRE_ONES;
                end
                PRE_ONES: begin
                    if (word_ones)      state_d = PRE_ONES;
                    else if (word_zero) state_d = PRE_ZERO1;
                end
                PRE_ZERO1: begin
                    if (word_ones) begin
                        state_d = PRE_ONES;
                    end else if (word_zero) begin
                        state_d = PRE_IDLE;
                        found_d = 1'b1;
                    end
                end
                default: state_d = PRE_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PRE_IDLE;
        else     state_q <= state_d;
    end

    // Output register, aligned with the output word register
    always_ff @(posedge clk) begin
        if (rst) found <= 1'b0;
        else     found <= found_d;
    end

endmodule

// File: rtl/trs_word_normalizer.sv
module trs_word_normalizer
    import trs_norm_pkg::*;
#(
    parameter int unsigned WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_dis,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_out,
    output logic              preamble_flag
);

    localparam int unsigned LOW_W = FORCED_LOW_BITS;

    logic [WORD_W-1:0] lat_word;
    logic              lat_dis;
    logic [WORD_W-1:0] map_word;
    logic              map_ones;
    logic              map_zero;
    logic [WORD_W-1:0] out_q;

    trs_input_latch #(.WORD_W(WORD_W)) latch_i (
        .clk    (clk),
        .rst    (rst),
        .d_word (word_in),
        .d_dis  (sync_dis),
        .q_word (lat_word),
        .q_dis  (lat_dis)
    );

    trs_word_mapper #(.WORD_W(WORD_W), .LOW_W(LOW_W)) mapper_i (
        .raw_word    (lat_word),
        .bypass      (lat_dis),
        .norm_word   (map_word),
        .is_all_ones (map_ones),
        .is_all_zero (map_zero)
    );

    trs_preamble_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .bypass    (lat_dis),
        .word_ones (map_ones),
        .word_zero (map_zero),
        .found     (preamble_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= map_word;
    end

    assign word_out = out_q;

endmodule

// File: rtl/trs_norm_chk.sv
module trs_norm_chk #(
    parameter int unsigned WORD_W = 10,
    parameter int unsigned LOW_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_dis,
    input logic [WORD_W-1:0] word_in,
    input logic [WORD_W-1:0] word_out,
    input logic              preamble_flag
);

    // Edges seen since reset, saturating, to keep history checks honest
    logic [2:0] live_cnt;
    always_ff @(posedge clk) begin
        if (rst)                  live_cnt <= 3'd0;
        else if (live_cnt != 3'd7) live_cnt <= live_cnt + 3'd1;
    end

    // R1
    low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (live_cnt >= 3'd2 && !$past(sync_dis, 2) &&
         $past(word_in[WORD_W-1:LOW_W], 2) == '0) |-> word_out == '0);

    // R2
    low_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (live_cnt >= 3'd2 && !$past(sync_dis, 2) &&
         &$past(word_in[WORD_W-1:LOW_W], 2)) |-> &word_out);

    // R4
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (live_cnt >= 3'd2 && $past(sync_dis, 2)) |-> word_out == $past(word_in, 2));

    // R8
    bypass_noflag_chk: assert property (@(posedge clk) disable iff (rst)
        (live_cnt >= 3'd2 && $past(sync_dis, 2)) |-> !preamble_flag);

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        preamble_flag |=> !preamble_flag);

    // R6
    flag_context_chk: assert property (@(posedge clk) disable iff (rst)
        (live_cnt >= 3'd4 && preamble_flag) |->
            (word_out == '0 && $past(word_out) == '0 && &$past(word_out, 2)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (word_out == '0 && !preamble_flag));

endmodule

bind trs_word_normalizer trs_norm_chk #(.WORD_W(WORD_W), .LOW_W(LOW_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .sync_dis      (sync_dis),
    .word_in       (word_in),
    .word_out      (word_out),
    .preamble_flag (preamble_flag)
);

// File: tb/trs_word_normalizer_tb_top.sv
`timescale 1ns/1ps
module trs_word_normalizer_tb_top;

    localparam int W = 10;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sync_dis = 1'b0;
    logic [W-1:0] word_in = '0;
    logic [W-1:0] word_out;
    logic         preamble_flag;

    always #2.5 clk = ~clk;

    trs_word_normalizer #(.WORD_W(W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .sync_dis      (sync_dis),
        .word_in       (word_in),
        .word_out      (word_out),
        .preamble_flag (preamble_flag)
    );

    typedef struct {
        logic [W-1:0] w;
        logic         f;
        int           due;
        string        wtag;
        string        ftag;
    } item_t;

    item_t        sb[$];
    item_t        cur;
    int           cyc = 0;
    int           vectors = 0;
    int           miscompares = 0;
    logic [W-1:0] h1 = '0, h2 = '0;
    logic         v1 = 1'b0, v2 = 1'b0;

    // Monitor: compare outputs against queued expectations just after each edge
    always begin
        @(posedge clk);
        cyc++;
        #1;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            cur = sb.pop_front();
            vectors++;
            if (cur.due != cyc || word_out !== cur.w) begin
                miscompares++;
                $display("FAIL %s word: actual %h expected %h", cur.wtag, word_out, cur.w);
            end
            vectors++;
            if (preamble_flag !== cur.f) begin
                miscompares++;
                $display("FAIL %s flag: actual %b expected %b", cur.ftag, preamble_flag, cur.f);
            end
        end
    end

    // Driver: apply one word and queue the expected result two edges later (R5)
    task automatic drive(input logic [W-1:0] w, input logic dis);
        logic [W-1:0] n;
        logic         f;
        item_t        it;
        @(negedge clk);
        word_in  = w;
        sync_dis = dis;
        if (dis) begin
            n = w;
            it.wtag = "R4/R5";
        end else if (w[W-1:2] == '0) begin
            n = '0;
            it.wtag = "R1/R5";
        end else if (&w[W-1:2]) begin
            n = ONES;
            it.wtag = "R2/R5";
        end else begin
            n = w;
            it.wtag = "R3/R5";
        end
        f = !dis && v1 && v2 && h1 == '0 && h2 == ONES && n == '0;
        it.ftag = dis ? "R8" : (f ? "R6" : "R7/R10");
        h2 = h1; v2 = v1;
        h1 = n;  v1 = !dis;
        it.w = n;
        it.f = f;
        it.due = cyc + 2;
        sb.push_back(it);
    endtask

    // Reset for two edges and check the cleared outputs (R9)
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        word_in = '0;
        sync_dis = 1'b0;
        sb.delete();
        v1 = 1'b0; v2 = 1'b0;
        repeat (2) @(negedge clk);
        vectors++;
        if (word_out !== '0 || preamble_flag !== 1'b0) begin
            miscompares++;
            $display("FAIL R9 reset: actual %h/%b expected 000/0", word_out, preamble_flag);
        end
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        do_reset();
        // R3 ordinary words and neighbours of the reserved ranges
        drive(10'h155, 0); drive(10'h2AA, 0); drive(10'h004, 0);
        drive(10'h3FB, 0); drive(10'h200, 0);
        // R1 and R2 every reserved value
        for (int i = 0; i < 4; i++) drive(10'(i), 0);
        for (int i = 0; i < 4; i++) drive(10'h3FC + 10'(i), 0);
        drive(10'h200, 0);
        // R6 clean preamble, then an eight-bit style one
        drive(10'h3FF, 0); drive(10'h000, 0); drive(10'h000, 0); drive(10'h274, 0);
        drive(10'h3FC, 0); drive(10'h003, 0); drive(10'h001, 0); drive(10'h2D8, 0);
        // R7 fourth zero must not fire
        drive(10'h3FF, 0); drive(10'h000, 0); drive(10'h000, 0); drive(10'h000, 0);
        // R10 repeated ones, broken run, restart inside a run
        drive(10'h3FF, 0); drive(10'h3FF, 0); drive(10'h000, 0); drive(10'h002, 0);
        drive(10'h3FF, 0); drive(10'h004, 0); drive(10'h000, 0); drive(10'h000, 0);
        drive(10'h3FF, 0); drive(10'h000, 0); drive(10'h3FF, 0); drive(10'h000, 0);
        drive(10'h000, 0);
        // R4 bypass keeps reserved values raw
        drive(10'h001, 1); drive(10'h002, 1); drive(10'h3FD, 1); drive(10'h3FE, 1);
        // R8 bypassed preamble, and a bypassed word inside a preamble
        drive(10'h3FF, 1); drive(10'h000, 1); drive(10'h000, 1);
        drive(10'h3FF, 0); drive(10'h000, 1); drive(10'h000, 0); drive(10'h000, 0);
        // R9 reset cuts a partial preamble
        drive(10'h3FF, 0); drive(10'h000, 0);
        do_reset();
        drive(10'h000, 0); drive(10'h000, 0);
        drive(10'h3FF, 0); drive(10'h000, 0); drive(10'h000, 0);
        drive(10'h123, 0); drive(10'h200, 0);
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule